// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block drives a shared serial-transmit pin. When it is switched off, the pin carries the serial transmitter's output unchanged. When it is switched on, the pin instead carries a keyed infrared drive waveform. That waveform is built from two carrier square waves, which come from neighbouring timers, and a single modulating data bit.

A configuration word is captured on a load strobe. It holds five bits:

- enable
- output inversion
- keying mode (amplitude or frequency shift)
- data source (hardware timer output or a stored software bit)
- the software data bit itself

The captured configuration is registered. Everything after it is combinational, so carrier and data edges reach the pin in the same cycle. The diode driver can therefore be wired active-high or active-low without any external gating.

In amplitude-shift keying, the pin follows carrier A while the data bit is 1 and sits idle (low) while it is 0. In frequency-shift keying, the pin follows carrier A for a 1 and carrier B for a 0. The inversion bit flips the keyed result only. It never affects pass-through.

Top module: `irmod_top`

## Requirements
- R1: After reset every configuration bit is 0, so the pin equals `serialTx` until a load occurs.
- R2: On a clock edge with `cfgLoad` high, the five configuration inputs are captured, and they take effect from that edge. Without `cfgLoad`, changes on those inputs have no effect on the pin.
- R3: With the enable bit (`cfgEnable`) captured as 0, `pinOut` equals `serialTx` for every value of carriers, data and the other configuration bits.
- R4: Enabled, with the mode bit (`cfgFsk`) 0 for amplitude keying, and the data bit 1: the keyed value equals `carrierA`.
- R5: Enabled, amplitude keying, data bit 0: the keyed value is 0 whatever the carriers do.
- R6: Enabled, with the mode bit 1 for frequency keying: the keyed value equals `carrierA` when the data bit is 1 and `carrierB` when it is 0.
- R7: When enabled, `pinOut` is the keyed value XOR the captured inversion bit (`cfgInvert`, 1 = inverted).
- R8: The data bit is `hwData` when the source bit (`cfgUseSw`) is 0, and the captured `cfgSwBit` when it is 1. The unselected source has no effect.
- R9: Changes on `carrierA`, `carrierB`, `hwData` and `serialTx` reach `pinOut` without waiting for a clock edge.
- R10: When enabled, `serialTx` has no effect on `pinOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Capture strobe for the configuration inputs |
| cfgEnable | input | 1 | 1 = keyed output drives the pin |
| cfgInvert | input | 1 | 1 = invert keyed output |
| cfgFsk | input | 1 | 0 = amplitude keying, 1 = frequency keying |
| cfgUseSw | input | 1 | 0 = hardware data, 1 = software data bit |
| cfgSwBit | input | 1 | Software data bit |
| carrierA | input | 1 | Primary carrier waveform |
| carrierB | input | 1 | Secondary carrier (frequency keying, data 0) |
| hwData | input | 1 | Hardware data from a timer output |
| serialTx | input | 1 | Serial transmitter output |
| pinOut | output | 1 | Shared pin drive |

## Verification
A corrupted configuration register shows up as a wrong pin level in the very next input combination that distinguishes the settings. Examples are a stuck enable that passes `serialTx` while keying is expected, or a flipped mode bit that shows `carrierB` where amplitude keying must idle. Because the datapath holds no state, a wrong mux selection is visible immediately, within the same cycle that the inputs change. Sweeping every captured configuration against every carrier/data/transmit combination, with probes between clock edges, exposes both kinds of error and any added clock of delay.

// File: rtl/irmod_pkg.sv
package irmod_pkg;
  // Captured configuration, handed from control to datapath
  typedef struct packed {
    logic enable;
    logic invert;
    logic fsk;
    logic useSw;
    logic swBit;
  } irCfg_t;

  localparam int CFG_W = $bits(irCfg_t);
  localparam irCfg_t CFG_RESET = '0;
endpackage

// File: rtl/irmod_ctrl.sv
module irmod_ctrl
  import irmod_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   load,
  input  irCfg_t cfgIn,
  output irCfg_t cfgQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfgQ <= CFG_RESET;
    else if (load)
      cfgQ <= cfgIn;
  end
endmodule

// File: rtl/irmod_datapath.sv
module irmod_datapath
  import irmod_pkg::*;
(
  input  irCfg_t cfg,
  input  logic   carrierA,
  input  logic   carrierB,
  input  logic   hwData,
  input  logic   serialTx,
  output logic   pinOut
);
  logic dataBit;
  logic keyed;

  always_comb begin
    dataBit = cfg.useSw ? cfg.swBit : hwData;
    if (cfg.fsk)
      keyed = dataBit ? carrierA : carrierB;
    else
      keyed = dataBit & carrierA;
    pinOut = cfg.enable ? (keyed ^ cfg.invert) : serialTx;
  end
endmodule

// File: rtl/irmod_top.sv
module irmod_top
  import irmod_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cfgLoad,
  input  logic cfgEnable,
  input  logic cfgInvert,
  input  logic cfgFsk,
  input  logic cfgUseSw,
  input  logic cfgSwBit,
  input  logic carrierA,
  input  logic carrierB,
  input  logic hwData,
  input  logic serialTx,
  output logic pinOut
);
  irCfg_t cfgIn;
  irCfg_t cfgQ;

  always_comb begin
    cfgIn.enable = cfgEnable;
    cfgIn.invert = cfgInvert;
    cfgIn.fsk    = cfgFsk;
    cfgIn.useSw  = cfgUseSw;
    cfgIn.swBit  = cfgSwBit;
  end

  irmod_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .load  (cfgLoad),
    .cfgIn (cfgIn),
    .cfgQ  (cfgQ)
  );

  irmod_datapath u_dp (
    .cfg      (cfgQ),
    .carrierA (carrierA),
    .carrierB (carrierB),
    .hwData   (hwData),
    .serialTx (serialTx),
    .pinOut   (pinOut)
  );
endmodule

// File: rtl/irmod_checker.sv
module irmod_checker
  import irmod_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   cfgLoad,
  input irCfg_t cfgIn,
  input irCfg_t cfgQ,
  input logic   carrierA,
  input logic   carrierB,
  input logic   hwData,
  input logic   serialTx,
  input logic   pinOut
);
  logic selData;
  assign selData = cfgQ.useSw ? cfgQ.swBit : hwData;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(cfgQ));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> cfgQ == $past(cfgIn));

  p_passthru_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.enable |-> pinOut == serialTx);

  p_ask_mark_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.enable && !cfgQ.fsk && selData) |-> pinOut == (carrierA ^ cfgQ.invert));

  p_ask_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.enable && !cfgQ.fsk && !selData) |-> pinOut == cfgQ.invert);

  p_fsk_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.enable && cfgQ.fsk && !selData) |-> pinOut == (carrierB ^ cfgQ.invert));
endmodule

bind irmod_top irmod_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgLoad  (cfgLoad),
  .cfgIn    (cfgIn),
  .cfgQ     (cfgQ),
  .carrierA (carrierA),
  .carrierB (carrierB),
  .hwData   (hwData),
  .serialTx (serialTx),
  .pinOut   (pinOut)
);

// File: tb/irmod_top_bench.sv
`timescale 1ns/1ps
module irmod_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic cfgEnable = 1'b0, cfgInvert = 1'b0, cfgFsk = 1'b0, cfgUseSw = 1'b0, cfgSwBit = 1'b0;
  logic carrierA = 1'b0, carrierB = 1'b0, hwData = 1'b0, serialTx = 1'b0;
  logic pinOut;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irmod_top u_irmod_top (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgEnable(cfgEnable), .cfgInvert(cfgInvert), .cfgFsk(cfgFsk),
    .cfgUseSw(cfgUseSw), .cfgSwBit(cfgSwBit),
    .carrierA(carrierA), .carrierB(carrierB), .hwData(hwData),
    .serialTx(serialTx), .pinOut(pinOut)
  );

  // cfg bits: [4]=enable [3]=invert [2]=fsk [1]=useSw [0]=swBit
  // in bits:  [3]=carrierA [2]=carrierB [1]=hwData [0]=serialTx
  function automatic logic expPin(input logic [4:0] c, input logic [3:0] i);
    int d;
    int k;
    if (c[4] == 1'b0) return i[0];                        // R3
    d = c[1] ? int'(c[0]) : int'(i[1]);                    // R8
    if (c[2]) k = d ? int'(i[3]) : int'(i[2]);             // R6
    else      k = d * int'(i[3]);                          // R4, R5
    return logic'((k + int'(c[3])) % 2);                   // R7, R10
  endfunction

  function automatic string reqOf(input logic [4:0] c, input logic [3:0] i);
    if (!c[4]) return "R3";
    if (c[2]) return "R6/R7/R8/R10";
    if ((c[1] ? c[0] : i[1]) == 1'b1) return "R4/R7/R8/R10";
    return "R5/R7/R8/R10";
  endfunction

  task automatic check(input string req, input logic exp);
    nVec++;
    if (pinOut !== exp) begin
      nBad++;
      $display("FAIL %s: pinOut=%b expected=%b (time %0t)", req, pinOut, exp, $time);
    end
  endtask

  task automatic setIn(input logic [3:0] i);
    {carrierA, carrierB, hwData, serialTx} = i;
  endtask

  task automatic loadCfg(input logic [4:0] c);
    @(negedge clk);
    {cfgEnable, cfgInvert, cfgFsk, cfgUseSw, cfgSwBit} = c;
    cfgLoad = 1'b1;
    @(posedge clk);
    #1 cfgLoad = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // R1: reset state is pass-through
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < 16; i++) begin
      setIn(4'(i));
      #0.5 check("R1", 1'(i % 2));
    end

    // Full sweep: every configuration against every input pattern
    for (int c = 0; c < 32; c++) begin
      loadCfg(5'(c));
      // R2: change configuration inputs without a load; must be ignored
      {cfgEnable, cfgInvert, cfgFsk, cfgUseSw, cfgSwBit} = ~5'(c);
      for (int i = 0; i < 16; i++) begin
        setIn(4'(i));
        // R9: sampled shortly after the input change, no clock edge between
        #0.3 check(reqOf(5'(c), 4'(i)), expPin(5'(c), 4'(i)));
        #0.2;
      end
      // R2: hold across several edges with no load
      repeat (2) @(posedge clk);
      #1 setIn(4'b1010);
      #0.5 check("R2", expPin(5'(c), 4'b1010));
    end

    // R2: load takes effect from the loading edge
    loadCfg(5'b00000);
    setIn(4'b1000);
    @(negedge clk);
    {cfgEnable, cfgInvert, cfgFsk, cfgUseSw, cfgSwBit} = 5'b10011;
    cfgLoad = 1'b1;
    #0.5 check("R2", 1'b0);  // before the edge: still pass-through (serialTx=0)
    @(posedge clk);
    #0.5 check("R2", 1'b1);  // after the edge: ASK, sw data 1, carrierA=1
    cfgLoad = 1'b0;

    // R1: reset again while enabled returns to pass-through
    @(negedge clk);
    rstN = 1'b0;
    setIn(4'b1001);
    #0.5 check("R1", 1'b1);
    setIn(4'b1000);
    #0.5 check("R1", 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule